// File: doc/BRIEF.md
# Linear Midpoint Interpolator with Hold Upsampler

This block forms the tail of an oversampling DAC interpolation chain. Samples arrive at eight times the base audio rate. For every incoming sample the block first produces the midpoint between it and the previous sample, then the sample itself. This doubles the rate to sixteen times the base rate and suppresses the spectral image at the eight-times rate. Each sixteen-times value is then held on the output for a fixed number of modulator clock-enable cycles, which lifts the rate to 128 or 256 times the base rate for a following noise shaper.

The input is a valid/ready stream. A sample transfers on a clock edge where both `in_valid` and `in_ready` are high. While `in_ready` is low the source must keep `in_valid` and `in_data` steady. The block lowers `in_ready` after each transfer and raises it again once both derived sixteen-times values have gone to the hold stage. The output is not a stream. It is a held register that the noise shaper reads at its own pace, so it has no back-pressure. The rate selector and the modulator enable are plain control pins. The 256x setting is meant for base rates from 8 kHz to 32 kHz, and 128x for faster rates.

Top module: `lih_top`

## Requirements
- R1: `in_ready` is high exactly when no sixteen-times value from an earlier transfer is still waiting for the hold stage. After a transfer it stays low until the midpoint and the sample have both been loaded.
- R2: For a transferred sample x with previous transferred sample p (p is 0 after reset), the hold stage receives floor((p+x)/2) first and then x.
- R3: The midpoint is formed from a sum one bit wider than the input, so full-scale inputs never wrap. For example, 32767 and 32767 give 32767, -32768 and -32768 give -32768, 32767 and -32768 give -1, and -3 and 0 give -2.
- R4: Each sixteen-times value stays on `out_data` for 8 `mod_ce` cycles when it was loaded with `rate_256` = 0, and for 16 when it was loaded with `rate_256` = 1.
- R5: `out_data` changes only on a clock edge where `mod_ce` is high, and it shows the new value from the cycle after that edge.
- R6: `rate_256` is sampled only on the edge that loads a new sixteen-times value. Changing it in the middle of a hold does not alter that hold's length.
- R7: If no value is waiting when a hold ends, `out_data` keeps its last value. The next value loads on the first `mod_ce` edge at which one is available.
- R8: After reset `out_data` is 0, `in_ready` is 1 and the hold stage is at a boundary, so the first value loads on the first `mod_ce` edge that finds it waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Eight-times sample offered |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | DATA_W | Signed eight-times sample |
| rate_256 | input | 1 | 1 selects 256x output, 0 selects 128x |
| mod_ce | input | 1 | Modulator-rate clock enable |
| out_data | output | DATA_W | Signed held output sample |

## Verification
A hold counter that drifts shows up as runs of the wrong length on `out_data`. The bench compares `out_data` against its model on every cycle, so such an error is caught on the first `mod_ce` after the run should have ended. A wrong slot state either lets an extra transfer through or blocks one, so `in_ready` disagrees with the model within one cycle. It also reorders or skips the midpoint and sample on the output within one hold period. A rounding or width error in the midpoint shows at the load of the affected value, and the full-scale and negative-odd patterns bring these out.

// File: rtl/lih_pkg.sv
package lih_pkg;

  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_MID   = 2'd1,
    SLOT_CUR   = 2'd2
  } slot_e;

  typedef enum logic {
    RATE_128X = 1'b0,
    RATE_256X = 1'b1
  } rate_e;

endpackage

// File: rtl/lih_interp.sv
module lih_interp
  import lih_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_data,
  input  logic                     take,
  output logic                     s16_valid,
  output logic signed [DATA_W-1:0] s16_data,
  output logic signed [DATA_W-1:0] prev_o,
  output logic signed [DATA_W-1:0] mid_o
);

  localparam int SUM_W = DATA_W + 1;

  slot_e                     slot_q;
  logic signed [DATA_W-1:0]  prev_q;
  logic signed [DATA_W-1:0]  mid_q;
  logic signed [DATA_W-1:0]  cur_q;
  logic        [SUM_W-1:0]   sum;
  logic                      accept;

  // sign-extended sum, one bit wider than the samples
  assign sum    = {prev_q[DATA_W-1], prev_q} + {in_data[DATA_W-1], in_data};
  assign in_ready = (slot_q == SLOT_EMPTY);
  assign accept = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= SLOT_EMPTY;
      prev_q <= '0;
      mid_q  <= '0;
      cur_q  <= '0;
    end else if (accept) begin
      prev_q <= in_data;
      cur_q  <= in_data;
      mid_q  <= sum[SUM_W-1:1];   // arithmetic shift right by one: floor
      slot_q <= SLOT_MID;
    end else if (take) begin
      slot_q <= (slot_q == SLOT_MID) ? SLOT_CUR : SLOT_EMPTY;
    end
  end

  assign s16_valid = (slot_q != SLOT_EMPTY);
  assign s16_data  = (slot_q == SLOT_MID) ? mid_q : cur_q;
  assign prev_o    = prev_q;
  assign mid_o     = mid_q;

endmodule

// File: rtl/lih_hold.sv
module lih_hold
  import lih_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int HOLD_LO = 8,
  parameter int HOLD_HI = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mod_ce,
  input  logic                     rate_256,
  input  logic                     s16_valid,
  input  logic signed [DATA_W-1:0] s16_data,
  output logic                     take,
  output logic signed [DATA_W-1:0] out_data,
  output logic                     rate_o,
  output logic [$clog2(HOLD_HI)-1:0] cnt_o
);

  localparam int CW = $clog2(HOLD_HI);
  localparam logic [CW-1:0] LAST_LO = CW'(HOLD_LO - 1);
  localparam logic [CW-1:0] LAST_HI = CW'(HOLD_HI - 1);

  rate_e                    rate_q;
  logic [CW-1:0]            cnt_q;
  logic [CW-1:0]            last;
  logic                     at_bnd;
  logic signed [DATA_W-1:0] hold_q;

  assign last   = (rate_q == RATE_256X) ? LAST_HI : LAST_LO;
  assign at_bnd = (cnt_q == last);
  assign take   = mod_ce && at_bnd && s16_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q <= RATE_128X;
      cnt_q  <= LAST_LO;
      hold_q <= '0;
    end else if (take) begin
      hold_q <= s16_data;
      cnt_q  <= '0;
      rate_q <= rate_e'(rate_256);
    end else if (mod_ce && !at_bnd) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign out_data = hold_q;
  assign rate_o   = rate_q;
  assign cnt_o    = cnt_q;

endmodule

// File: rtl/lih_top.sv
module lih_top #(
  parameter int DATA_W  = 16,
  parameter int HOLD_LO = 8,
  parameter int HOLD_HI = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_data,
  input  logic                     rate_256,
  input  logic                     mod_ce,
  output logic signed [DATA_W-1:0] out_data
);

  localparam int CW = $clog2(HOLD_HI);

  logic                     s16_valid;
  logic signed [DATA_W-1:0] s16_data;
  logic                     take;
  logic signed [DATA_W-1:0] prev_w;
  logic signed [DATA_W-1:0] mid_w;
  logic                     rate_w;
  logic [CW-1:0]            cnt_w;

  lih_interp #(.DATA_W(DATA_W)) interp_u (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .take      (take),
    .s16_valid (s16_valid),
    .s16_data  (s16_data),
    .prev_o    (prev_w),
    .mid_o     (mid_w)
  );

  lih_hold #(.DATA_W(DATA_W), .HOLD_LO(HOLD_LO), .HOLD_HI(HOLD_HI)) hold_u (
    .clk       (clk),
    .rst_n     (rst_n),
    .mod_ce    (mod_ce),
    .rate_256  (rate_256),
    .s16_valid (s16_valid),
    .s16_data  (s16_data),
    .take      (take),
    .out_data  (out_data),
    .rate_o    (rate_w),
    .cnt_o     (cnt_w)
  );

endmodule

// File: rtl/lih_chk.sv
module lih_chk #(
  parameter int DATA_W  = 16,
  parameter int HOLD_LO = 8,
  parameter int HOLD_HI = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic signed [DATA_W-1:0]   in_data,
  input logic                       mod_ce,
  input logic signed [DATA_W-1:0]   out_data,
  input logic signed [DATA_W-1:0]   prev_w,
  input logic signed [DATA_W-1:0]   mid_w,
  input logic                       rate_w,
  input logic                       take,
  input logic [$clog2(HOLD_HI)-1:0] cnt_w
);

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R1

  AST_MID_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=>
      (($past(prev_w) <= $past(in_data)) ?
        (mid_w >= $past(prev_w) && mid_w <= $past(in_data)) :
        (mid_w >= $past(in_data) && mid_w <= $past(prev_w)))); // R3

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_w) <= (rate_w ? HOLD_HI - 1 : HOLD_LO - 1)); // R4

  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_ce |=> $stable(out_data)); // R5

  AST_RATE_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(rate_w)); // R6

endmodule

bind lih_top lih_chk #(.DATA_W(DATA_W), .HOLD_LO(HOLD_LO), .HOLD_HI(HOLD_HI)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_data  (in_data),
  .mod_ce   (mod_ce),
  .out_data (out_data),
  .prev_w   (prev_w),
  .mid_w    (mid_w),
  .rate_w   (rate_w),
  .take     (take),
  .cnt_w    (cnt_w)
);

// File: tb/lih_top_tb_top.sv
module lih_top_tb_top;

  localparam int DW = 16;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic signed [DW-1:0] in_data = '0;
  logic                 rate_256 = 1'b0;
  logic                 mod_ce = 1'b0;
  logic signed [DW-1:0] out_data;

  int n_chk = 0;
  int n_fail = 0;

  // bench model state
  int    stim[$];
  int    exp_q[$];
  int    exp_cur = 0;
  int    prev_m = 0;
  int    run_pos = 0;
  int    run_len = 8;
  string tag = "R8";

  always #2.5 clk = ~clk;

  lih_top #(.DATA_W(DW)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .rate_256 (rate_256),
    .mod_ce   (mod_ce),
    .out_data (out_data)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one clock cycle, entered and left at a falling edge
  task automatic cyc(input bit ce);
    bit hs;
    int x;
    mod_ce   = ce;
    in_valid = (stim.size() > 0);
    in_data  = (stim.size() > 0) ? DW'(stim[0]) : '0;
    check("R1", int'(in_ready), int'(exp_q.size() == 0));
    hs = in_valid && (exp_q.size() == 0);
    if (ce) begin
      if (run_pos == 0) begin
        if (exp_q.size() > 0) begin       // load at boundary
          exp_cur = exp_q.pop_front();
          run_len = rate_256 ? 16 : 8;
          run_pos = 1;
        end                               // else R7: keep last value
      end else begin
        run_pos++;
      end
      if (run_pos == run_len) run_pos = 0;
    end
    @(posedge clk);
    if (hs) begin
      x = stim.pop_front();
      exp_q.push_back((prev_m + x) >>> 1);
      exp_q.push_back(x);
      prev_m = x;
    end
    @(negedge clk);
    check(tag, int'(out_data), exp_cur);
  endtask

  task automatic run(input int ncyc, input int ce_per);
    for (int i = 0; i < ncyc; i++) cyc((i % ce_per) == 0);
  endtask

  task automatic drain(input int ce_per);
    int guard = 0;
    while ((stim.size() > 0 || exp_q.size() > 0 || run_pos != 0) && guard < 20000) begin
      cyc((guard % ce_per) == 0);
      guard++;
    end
  endtask

  task automatic t_reset;
    tag = "R8";
    check("R8", int'(out_data), 0);
    check("R8", int'(in_ready), 1);
    run(6, 1);                 // no input: output stays at reset value
  endtask

  task automatic t_ramp;
    tag = "R2";
    rate_256 = 1'b0;
    stim = '{100, 200, -50, -51, 7, 1000};
    drain(2);
  endtask

  task automatic t_fast;
    tag = "R4";
    rate_256 = 1'b1;
    stim = '{-20, 40, 41, -9};
    drain(1);
    rate_256 = 1'b0;
    stim = '{3, 5};
    drain(1);
  endtask

  task automatic t_extremes;
    tag = "R3";
    stim = '{32767, 32767, -32768, -32768, 32767, -3, 0};
    drain(1);
  endtask

  task automatic t_switch;
    tag = "R6";
    rate_256 = 1'b0;
    stim = '{11, 22, 33, 44, 55};
    run(13, 1);               // mid-hold: flip selector
    rate_256 = 1'b1;
    run(21, 1);
    rate_256 = 1'b0;
    drain(1);
  endtask

  task automatic t_gaps;
    tag = "R5";
    stim = '{-700, 700, 1, -1};
    drain(3);
    rate_256 = 1'b1;
    stim = '{9, 90};
    drain(4);
    rate_256 = 1'b0;
  endtask

  task automatic t_underflow;
    tag = "R7";
    stim = '{1234};
    drain(1);
    run(60, 1);               // nothing waiting: last value held
    check("R7", int'(out_data), 1234);
    stim = '{-4321};
    drain(2);
  endtask

  initial begin
    #200000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_ramp;
    t_fast;
    t_extremes;
    t_switch;
    t_gaps;
    t_underflow;
    run(10, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule